// File: doc/BRIEF.md
# Debug scan-chain command decoder

This block sits behind an existing JTAG TAP controller. It receives the Capture-DR, Shift-DR and Update-DR strobes, the serial input bit and the current 4-bit instruction. From these it assembles each data-register frame, least significant bit first. A separate frame, protected by an 8-bit CRC, chooses the active debug chain. On the processor-debug chain and on the register-scan chain, every frame carries an address, a direction bit, a data word and a CRC byte.

A frame whose length and CRC are both correct becomes one request. The request crosses from the TCK domain into the system clock domain through a toggle handshake. There it produces a single-cycle access: either on the processor port (32-bit address) or on an internal register file (5-bit address). Read results are held, and the next debug scan shifts them out on TDO. A busy flag tells the host when the previous request has completed. A crc-error flag reports whether the last checked frame was rejected.

Top module: `dbg_chain_decoder`

## Requirements
- R1: Instruction codes are EXTEST 0x0, SAMPLE_PRELOAD 0x1, IDCODE 0x2, CHAIN_SELECT 0x3, INTEST 0x4, CLAMP 0x5, CLAMPZ 0x6, HIGHZ 0x7, DEBUG 0x8 and BYPASS 0xF. Any other code decodes as BYPASS. Under every instruction except IDCODE, CHAIN_SELECT and DEBUG, TDO comes from a one-bit register that is cleared at Capture-DR and loaded from TDI on each shift. Shift k therefore outputs the TDI bit of shift k-1, and shift 0 outputs 0.
- R2: Under IDCODE, shift k (k < 32) presents bit k of the ID_VALUE parameter on TDO.
- R3: A chain-select frame is 12 bits: the chain id in bits 3:0 and the CRC in bits 11:4. The ids are 0 global boundary scan, 1 processor debug, 2 processor test, 3 trace test and 4 register scan. The active chain changes only on a frame of exactly 12 bits with a matching CRC. After reset the active chain is 0.
- R4: The CRC is CRC-8 with polynomial 0x07 (x^8+x^2+x+1), preset to 0xFF. It is shifted MSB-out over the non-CRC bits in shift order, and received CRC bit i sits at frame position (CRC offset + i). A checked frame with a wrong CRC or a wrong bit count does nothing and sets crc_err_o to 1. A correct checked frame clears crc_err_o. crc_err_o is 0 after reset and changes only at Update-DR.
- R5: A processor-debug frame is 73 bits: address in bits 31:0, direction in bit 32 (1 = write), data in bits 64:33 and CRC in bits 72:65. An accepted write raises cpu_cs_o for exactly one clk_i cycle, with cpu_we_o=1, the frame address on cpu_addr_o and the frame data on cpu_wdata_o.
- R6: An accepted processor read gives one cpu_cs_o pulse with cpu_we_o=0. The data field of the frame is ignored. cpu_rdata_i is sampled in the pulse cycle, and the next DEBUG scan shifts that value out, bit k on shift k.
- R7: A register-scan frame is 46 bits: address in bits 4:0, direction in bit 5, data in bits 37:6 and CRC in bits 45:38. An accepted write to an address below NUM_REGS updates that register, which is visible on regs_o[32*a +: 32].
- R8: A register read returns the register value in the next DEBUG scan. An address at or above NUM_REGS reads as 0xFFFFFFFF, and writing to such an address changes no register.
- R9: busy_o is 0 after reset. It is 1 from the Update-DR edge that accepts a request until the completion has returned to the TCK domain. A correct frame that arrives while busy_o is 1 is discarded.
- R10: DEBUG scans are not checked and issue no request unless the active chain is 1 or 4; such scans leave crc_err_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| capture_dr_i | input | 1 | Capture-DR strobe from the TAP |
| shift_dr_i | input | 1 | Shift-DR strobe from the TAP |
| update_dr_i | input | 1 | Update-DR strobe from the TAP |
| tdi_i | input | 1 | Serial input bit |
| ir_i | input | 4 | Current instruction code |
| tdo_o | output | 1 | Serial output bit |
| crc_err_o | output | 1 | Last checked frame was rejected |
| busy_o | output | 1 | Request in flight (TCK domain) |
| cpu_cs_o | output | 1 | One-cycle processor access strobe |
| cpu_we_o | output | 1 | Processor access is a write |
| cpu_addr_o | output | 32 | Processor access address |
| cpu_wdata_o | output | 32 | Processor write data |
| cpu_rdata_i | input | 32 | Processor read data |
| regs_o | output | 32*NUM_REGS | Contents of the internal register file |

## Verification
The bench writes every register, then reads it back through the scan path. It also aims writes and reads at addresses past the end of the file. A decoder that wrapped the address would corrupt a real register, and one without a default would return stale data instead of all ones. Frames with a flipped CRC bit or one bit missing must set the error flag and leave state untouched; a design that trusted the length would act on a truncated frame. With the system clock held, a second correct write must be dropped, so that only the first value lands. Debug scans on the default chain and on the trace chain must issue nothing and leave a pending error in place.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
  localparam int DW       = 32;
  localparam int CPU_AW   = 32;
  localparam int REG_AW   = 5;
  localparam int CRC_W    = 8;
  localparam int CID_W    = 4;
  localparam int SEL_DLEN = CID_W;
  localparam int SEL_LEN  = SEL_DLEN + CRC_W;
  localparam int CPU_DLEN = CPU_AW + 1 + DW;
  localparam int CPU_LEN  = CPU_DLEN + CRC_W;
  localparam int REG_DLEN = REG_AW + 1 + DW;
  localparam int REG_LEN  = REG_DLEN + CRC_W;
  localparam int IDX_W    = $clog2(CPU_LEN);
  localparam int CNT_W    = IDX_W + 1;
  localparam int DIDX_W   = $clog2(DW);

  typedef enum logic [3:0] {
    I_EXTEST = 4'h0, I_SAMPLE = 4'h1, I_IDCODE = 4'h2, I_CHSEL  = 4'h3,
    I_INTEST = 4'h4, I_CLAMP  = 4'h5, I_CLAMPZ = 4'h6, I_HIGHZ  = 4'h7,
    I_DEBUG  = 4'h8, I_BYPASS = 4'hF
  } instr_e;

  typedef enum logic [CID_W-1:0] {
    CH_GBS = 4'd0, CH_CPU = 4'd1, CH_CPUTEST = 4'd2, CH_TRACE = 4'd3, CH_REGS = 4'd4
  } chain_e;

  function automatic instr_e decode_ir(logic [3:0] code);
    case (code)
      4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8: return instr_e'(code);
      default: return I_BYPASS;
    endcase
  endfunction
endpackage

// File: rtl/dbgc_crc8.sv
module dbgc_crc8 #(
  parameter int             W    = 8,
  parameter logic [W-1:0]   POLY = 8'h07,
  parameter logic [W-1:0]   INIT = 8'hFF
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb    = crc_q[W-1] ^ bit_i;
  assign crc_o = crc_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= INIT;
    else if (init_i) crc_q <= INIT;
    else if (en_i)   crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end
endmodule

// File: rtl/dbgc_tck_front.sv
module dbgc_tck_front
  import dbgc_pkg::*;
#(
  parameter logic [DW-1:0] ID_VALUE = 32'h4D1C_0A37
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              capture_dr_i,
  input  logic              shift_dr_i,
  input  logic              update_dr_i,
  input  logic              tdi_i,
  input  logic [3:0]        ir_i,
  output logic              tdo_o,
  output logic              crc_err_o,
  output logic              busy_o,
  output logic              req_tgl_o,
  input  logic              ack_tgl_i,
  output logic              cmd_cpu_o,
  output logic              cmd_we_o,
  output logic [CPU_AW-1:0] cmd_addr_o,
  output logic [DW-1:0]     cmd_wdata_o,
  input  logic [DW-1:0]     rd_data_i
);
  localparam logic [CNT_W-1:0] SEL_LEN_C  = CNT_W'(SEL_LEN);
  localparam logic [CNT_W-1:0] CPU_LEN_C  = CNT_W'(CPU_LEN);
  localparam logic [CNT_W-1:0] REG_LEN_C  = CNT_W'(REG_LEN);
  localparam logic [CNT_W-1:0] SEL_DLEN_C = CNT_W'(SEL_DLEN);
  localparam logic [CNT_W-1:0] CPU_DLEN_C = CNT_W'(CPU_DLEN);
  localparam logic [CNT_W-1:0] REG_DLEN_C = CNT_W'(REG_DLEN);
  localparam logic [CNT_W-1:0] DW_C       = CNT_W'(DW);

  instr_e             ins;
  logic               on_sel, on_dbg, chain_cpu, chain_reg, dbg_live;
  logic [CNT_W-1:0]   cnt_q, dlen, flen;
  logic [CPU_LEN-1:0] frame_q;
  logic [CRC_W-1:0]   crc_rx, crc_calc;
  logic [CID_W-1:0]   chain_q;
  logic               frame_ok, bypass_q, crc_err_q, req_q;
  logic [1:0]         ack_s;

  assign ins       = decode_ir(ir_i);
  assign on_sel    = (ins == I_CHSEL);
  assign on_dbg    = (ins == I_DEBUG);
  assign chain_cpu = (chain_q == CH_CPU);
  assign chain_reg = (chain_q == CH_REGS);
  assign dbg_live  = on_dbg & (chain_cpu | chain_reg);

  always_comb begin
    if (on_sel) begin
      dlen = SEL_DLEN_C; flen = SEL_LEN_C; crc_rx = frame_q[SEL_LEN-1 -: CRC_W];
    end else if (chain_cpu) begin
      dlen = CPU_DLEN_C; flen = CPU_LEN_C; crc_rx = frame_q[CPU_LEN-1 -: CRC_W];
    end else begin
      dlen = REG_DLEN_C; flen = REG_LEN_C; crc_rx = frame_q[REG_LEN-1 -: CRC_W];
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (capture_dr_i)                cnt_q <= '0;
    else if (shift_dr_i && cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) frame_q <= '0;
    else if (shift_dr_i && cnt_q < CPU_LEN_C) frame_q[cnt_q[IDX_W-1:0]] <= tdi_i;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)           bypass_q <= 1'b0;
    else if (capture_dr_i) bypass_q <= 1'b0;
    else if (shift_dr_i)   bypass_q <= tdi_i;
  end

  dbgc_crc8 #(.W(CRC_W), .POLY(8'h07), .INIT(8'hFF)) u_crc (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .init_i (capture_dr_i),
    .en_i   (shift_dr_i && (cnt_q < dlen)),
    .bit_i  (tdi_i),
    .crc_o  (crc_calc)
  );

  // length and checksum must both agree
  assign frame_ok = (cnt_q == flen) && (crc_rx == crc_calc);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) ack_s <= '0;
    else         ack_s <= {ack_s[0], ack_tgl_i};
  end

  assign busy_o = req_q ^ ack_s[1];

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q     <= CH_GBS;
      crc_err_q   <= 1'b0;
      req_q       <= 1'b0;
      cmd_cpu_o   <= 1'b0;
      cmd_we_o    <= 1'b0;
      cmd_addr_o  <= '0;
      cmd_wdata_o <= '0;
    end else if (update_dr_i) begin
      if (on_sel) begin
        crc_err_q <= !frame_ok;
        if (frame_ok) chain_q <= frame_q[CID_W-1:0];
      end else if (dbg_live) begin
        crc_err_q <= !frame_ok;
        if (frame_ok && !busy_o) begin
          req_q     <= !req_q;
          cmd_cpu_o <= chain_cpu;
          if (chain_cpu) begin
            cmd_addr_o  <= frame_q[CPU_AW-1:0];
            cmd_we_o    <= frame_q[CPU_AW];
            cmd_wdata_o <= frame_q[CPU_AW+1 +: DW];
          end else begin
            cmd_addr_o  <= CPU_AW'(frame_q[REG_AW-1:0]);
            cmd_we_o    <= frame_q[REG_AW];
            cmd_wdata_o <= frame_q[REG_AW+1 +: DW];
          end
        end
      end
    end
  end

  assign crc_err_o = crc_err_q;
  assign req_tgl_o = req_q;

  always_comb begin
    if (ins == I_IDCODE)      tdo_o = (cnt_q < DW_C) ? ID_VALUE[cnt_q[DIDX_W-1:0]] : 1'b0;
    else if (dbg_live)        tdo_o = (cnt_q < DW_C) ? rd_data_i[cnt_q[DIDX_W-1:0]] : 1'b0;
    else if (on_sel || on_dbg) tdo_o = 1'b0;
    else                      tdo_o = bypass_q;
  end
endmodule

// File: rtl/dbgc_sys_exec.sv
module dbgc_sys_exec
  import dbgc_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_tgl_i,
  output logic                   ack_tgl_o,
  input  logic                   cmd_cpu_i,
  input  logic                   cmd_we_i,
  input  logic [CPU_AW-1:0]      cmd_addr_i,
  input  logic [DW-1:0]          cmd_wdata_i,
  output logic                   cpu_cs_o,
  output logic                   cpu_we_o,
  output logic [CPU_AW-1:0]      cpu_addr_o,
  output logic [DW-1:0]          cpu_wdata_o,
  input  logic [DW-1:0]          cpu_rdata_i,
  output logic [NUM_REGS*DW-1:0] regs_o,
  output logic [DW-1:0]          rd_data_o
);
  logic [2:0]        req_s;
  logic              fire, reg_go;
  logic [REG_AW-1:0] reg_addr;
  logic [DW-1:0]     regs_q [NUM_REGS];
  logic [DW-1:0]     reg_rd, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_s <= '0;
    else         req_s <= {req_s[1:0], req_tgl_i};
  end

  assign fire        = req_s[2] ^ req_s[1];
  assign ack_tgl_o   = req_s[2];
  assign cpu_cs_o    = fire & cmd_cpu_i;
  assign cpu_we_o    = cmd_we_i;
  assign cpu_addr_o  = cmd_addr_i;
  assign cpu_wdata_o = cmd_wdata_i;
  assign reg_go      = fire & ~cmd_cpu_i;
  assign reg_addr    = cmd_addr_i[REG_AW-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (reg_go && cmd_we_i && reg_addr == REG_AW'(g)) regs_q[g] <= cmd_wdata_i;
    end
    assign regs_o[g*DW +: DW] = regs_q[g];
  end

  // unmapped addresses read as all ones
  always_comb begin
    reg_rd = '1;
    for (int i = 0; i < NUM_REGS; i++)
      if (reg_addr == REG_AW'(i)) reg_rd = regs_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rd_q <= '0;
    else if (fire && !cmd_we_i) rd_q <= cmd_cpu_i ? cpu_rdata_i : reg_rd;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/dbg_chain_decoder.sv
module dbg_chain_decoder
  import dbgc_pkg::*;
#(
  parameter int            NUM_REGS = 4,
  parameter logic [DW-1:0] ID_VALUE = 32'h4D1C_0A37
) (
  input  logic                   clk_i,
  input  logic                   tck_i,
  input  logic                   rst_ni,
  input  logic                   capture_dr_i,
  input  logic                   shift_dr_i,
  input  logic                   update_dr_i,
  input  logic                   tdi_i,
  input  logic [3:0]             ir_i,
  output logic                   tdo_o,
  output logic                   crc_err_o,
  output logic                   busy_o,
  output logic                   cpu_cs_o,
  output logic                   cpu_we_o,
  output logic [CPU_AW-1:0]      cpu_addr_o,
  output logic [DW-1:0]          cpu_wdata_o,
  input  logic [DW-1:0]          cpu_rdata_i,
  output logic [NUM_REGS*DW-1:0] regs_o
);
  logic              req_tgl, ack_tgl, cmd_cpu, cmd_we;
  logic [CPU_AW-1:0] cmd_addr;
  logic [DW-1:0]     cmd_wdata, rd_data;

  dbgc_tck_front #(.ID_VALUE(ID_VALUE)) u_front (
    .tck_i        (tck_i),
    .rst_ni       (rst_ni),
    .capture_dr_i (capture_dr_i),
    .shift_dr_i   (shift_dr_i),
    .update_dr_i  (update_dr_i),
    .tdi_i        (tdi_i),
    .ir_i         (ir_i),
    .tdo_o        (tdo_o),
    .crc_err_o    (crc_err_o),
    .busy_o       (busy_o),
    .req_tgl_o    (req_tgl),
    .ack_tgl_i    (ack_tgl),
    .cmd_cpu_o    (cmd_cpu),
    .cmd_we_o     (cmd_we),
    .cmd_addr_o   (cmd_addr),
    .cmd_wdata_o  (cmd_wdata),
    .rd_data_i    (rd_data)
  );

  dbgc_sys_exec #(.NUM_REGS(NUM_REGS)) u_exec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_tgl_i   (req_tgl),
    .ack_tgl_o   (ack_tgl),
    .cmd_cpu_i   (cmd_cpu),
    .cmd_we_i    (cmd_we),
    .cmd_addr_i  (cmd_addr),
    .cmd_wdata_i (cmd_wdata),
    .cpu_cs_o    (cpu_cs_o),
    .cpu_we_o    (cpu_we_o),
    .cpu_addr_o  (cpu_addr_o),
    .cpu_wdata_o (cpu_wdata_o),
    .cpu_rdata_i (cpu_rdata_i),
    .regs_o      (regs_o),
    .rd_data_o   (rd_data)
  );
endmodule

// File: rtl/dbgc_checker.sv
module dbgc_checker (
  input logic clk_i,
  input logic tck_i,
  input logic rst_ni,
  input logic update_dr_i,
  input logic busy_o,
  input logic crc_err_o,
  input logic cpu_cs_o,
  input logic req_tgl
);
  assert_cs_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_cs_o |=> !cpu_cs_o);

  assert_cs_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_cs_o |-> busy_o);

  assert_req_hold_R9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (busy_o && update_dr_i) |=> $stable(req_tgl));

  assert_err_update_R4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !update_dr_i |=> $stable(crc_err_o));
endmodule

bind dbg_chain_decoder dbgc_checker u_chk (
  .clk_i       (clk_i),
  .tck_i       (tck_i),
  .rst_ni      (rst_ni),
  .update_dr_i (update_dr_i),
  .busy_o      (busy_o),
  .crc_err_o   (crc_err_o),
  .cpu_cs_o    (cpu_cs_o),
  .req_tgl     (req_tgl)
);

// File: tb/sim_dbg_chain_decoder.sv
module sim_dbg_chain_decoder;
  localparam int          CLK_PERIOD = 10;
  localparam int          TCK_HALF   = 7;
  localparam int          NREGS      = 4;
  localparam logic [31:0] IDV        = 32'h4D1C_0A37;

  logic clk = 1'b0, tck = 1'b0, rst_n = 1'b0, clk_run = 1'b1;
  logic cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic [3:0]  ir = 4'hF;
  logic        tdo, crc_err, busy, cs, we;
  logic [31:0] addr, wdata, rdata = '0;
  logic [NREGS*32-1:0] regs;

  int n_chk = 0, n_fail = 0;
  int cs_cnt = 0;
  logic        cs_we;
  logic [31:0] cs_addr, cs_data;

  dbg_chain_decoder #(.NUM_REGS(NREGS), .ID_VALUE(IDV)) u0 (
    .clk_i(clk), .tck_i(tck), .rst_ni(rst_n),
    .capture_dr_i(cap), .shift_dr_i(sh), .update_dr_i(upd), .tdi_i(tdi), .ir_i(ir),
    .tdo_o(tdo), .crc_err_o(crc_err), .busy_o(busy),
    .cpu_cs_o(cs), .cpu_we_o(we), .cpu_addr_o(addr), .cpu_wdata_o(wdata),
    .cpu_rdata_i(rdata), .regs_o(regs)
  );

  initial forever begin
    #(CLK_PERIOD/2);
    if (clk_run) clk = ~clk;
  end

  always @(negedge clk) if (cs) begin
    cs_cnt++; cs_we = we; cs_addr = addr; cs_data = wdata;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] reg_at(int i);
    return regs[i*32 +: 32];
  endfunction

  function automatic logic [7:0] crc_of(logic [127:0] b, int n);
    logic [7:0] c;
    c = 8'hFF;
    for (int i = 0; i < n; i++) begin
      logic fb;
      fb = c[7] ^ b[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [127:0] mk_sel(logic [3:0] id);
    logic [127:0] f;
    f = '0; f[3:0] = id; f[11:4] = crc_of(f, 4);
    return f;
  endfunction

  function automatic logic [127:0] mk_cpu(logic [31:0] a, logic w, logic [31:0] d);
    logic [127:0] f;
    f = '0; f[31:0] = a; f[32] = w; f[64:33] = d; f[72:65] = crc_of(f, 65);
    return f;
  endfunction

  function automatic logic [127:0] mk_reg(logic [4:0] a, logic w, logic [31:0] d);
    logic [127:0] f;
    f = '0; f[4:0] = a; f[5] = w; f[37:6] = d; f[45:38] = crc_of(f, 38);
    return f;
  endfunction

  task automatic pulse();
    #TCK_HALF tck = 1'b1;
    #TCK_HALF tck = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) pulse();
  endtask

  task automatic scan(input logic [127:0] din, input int n, output logic [127:0] dout);
    dout = '0;
    cap = 1'b1; pulse(); cap = 1'b0;
    sh = 1'b1;
    for (int k = 0; k < n; k++) begin
      tdi = din[k];
      #1 dout[k] = tdo;
      pulse();
    end
    sh = 1'b0; upd = 1'b1; pulse(); upd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] o;
    logic [127:0] f;
    logic [31:0]  v [NREGS];
    int           c0;

    #(CLK_PERIOD*3) rst_n = 1'b1;
    #(CLK_PERIOD*2);

    // reset state
    check("R4 reset crc_err", {31'b0, crc_err}, 32'd0);
    check("R9 reset busy", {31'b0, busy}, 32'd0);
    for (int i = 0; i < NREGS; i++) check("R7 reset reg", reg_at(i), 32'd0);

    // R2 IDCODE
    ir = 4'h2;
    scan('0, 32, o);
    check("R2 idcode", o[31:0], IDV);

    // R1 bypass path for BYPASS, an unknown code and EXTEST
    foreach (ir[i]) ; // no-op
    for (int t = 0; t < 3; t++) begin
      logic [127:0] pat;
      ir  = (t == 0) ? 4'hF : (t == 1) ? 4'hB : 4'h0;
      pat = 128'h0000_0000_0000_0000_0000_0000_0000_B3C5 ^ 128'(t * 16'h1111);
      scan(pat, 16, o);
      check("R1 bypass delay", o[15:0], {pat[14:0], 1'b0});
    end

    // R3/R4 bad chain select keeps chain 0, sets error
    ir = 4'h3;
    f = mk_sel(4'd4); f[9] = ~f[9];
    scan(f, 12, o);
    check("R4 bad select crc_err", {31'b0, crc_err}, 32'd1);
    // R10 default chain 0: debug scan ignored, error kept
    ir = 4'h8;
    scan(mk_reg(5'd0, 1'b1, 32'hDEAD_BEEF), 46, o);
    idle(20);
    check("R10 no request on chain 0", reg_at(0), 32'd0);
    check("R10 crc_err unchanged", {31'b0, crc_err}, 32'd1);

    // R3 wrong length select rejected
    ir = 4'h3;
    scan(mk_sel(4'd4), 11, o);
    check("R3 short select crc_err", {31'b0, crc_err}, 32'd1);
    scan(mk_sel(4'd4), 12, o);
    check("R3 good select clears err", {31'b0, crc_err}, 32'd0);

    // R7 write every register
    ir = 4'h8;
    for (int a = 0; a < NREGS; a++) begin
      v[a] = 32'hC0DE_0000 | 32'(a * 32'h0000_1357) | 32'(a << 24);
      scan(mk_reg(5'(a), 1'b1, v[a]), 46, o);
      check("R9 busy after accept", {31'b0, busy}, 32'd1);
      idle(20);
      check("R9 busy clears", {31'b0, busy}, 32'd0);
    end
    for (int a = 0; a < NREGS; a++) check("R7 reg written", reg_at(a), v[a]);

    // R8 reads back, data field ignored on reads
    for (int a = 0; a < NREGS; a++) begin
      scan(mk_reg(5'(a), 1'b0, 32'h5555_AAAA), 46, o);
      idle(20);
      scan(mk_reg(5'(a), 1'b0, 32'h0), 46, o);
      idle(20);
      check("R8 reg readback", o[31:0], v[a]);
    end

    // R8 unmapped addresses
    for (int t = 0; t < 2; t++) begin
      logic [4:0] ua;
      ua = (t == 0) ? 5'(NREGS) : 5'h1F;
      scan(mk_reg(ua, 1'b1, 32'h0BAD_0BAD), 46, o);
      idle(20);
      for (int a = 0; a < NREGS; a++) check("R8 no corruption", reg_at(a), v[a]);
      scan(mk_reg(ua, 1'b0, 32'h0), 46, o);
      idle(20);
      scan(mk_reg(ua, 1'b0, 32'h0), 46, o);
      idle(20);
      check("R8 unmapped reads ones", o[31:0], 32'hFFFF_FFFF);
    end

    // R4 bad CRC and bad length on a register write
    f = mk_reg(5'd1, 1'b1, 32'h1234_5678); f[40] = ~f[40];
    scan(f, 46, o); idle(20);
    check("R4 bad crc err", {31'b0, crc_err}, 32'd1);
    check("R4 bad crc no write", reg_at(1), v[1]);
    scan(mk_reg(5'd1, 1'b1, 32'h1234_5678), 45, o); idle(20);
    check("R4 short frame err", {31'b0, crc_err}, 32'd1);
    check("R4 short frame no write", reg_at(1), v[1]);

    // R9 frame while busy is dropped (system clock held)
    clk_run = 1'b0;
    #(CLK_PERIOD);
    scan(mk_reg(5'd2, 1'b1, 32'h1111_2222), 46, o);
    check("R4 good frame clears err", {31'b0, crc_err}, 32'd0);
    check("R9 busy held", {31'b0, busy}, 32'd1);
    scan(mk_reg(5'd2, 1'b1, 32'h3333_4444), 46, o);
    idle(10);
    check("R9 no write while clock held", reg_at(2), v[2]);
    clk_run = 1'b1;
    idle(20);
    check("R9 busy released", {31'b0, busy}, 32'd0);
    check("R9 second frame dropped", reg_at(2), 32'h1111_2222);

    // R5/R6 processor chain
    ir = 4'h3;
    scan(mk_sel(4'd1), 12, o);
    ir = 4'h8;
    for (int t = 0; t < 3; t++) begin
      logic [31:0] ta, td;
      ta = (t == 0) ? 32'h0 : (t == 1) ? 32'hFFFF_FFFC : 32'h8000_1234;
      td = 32'h9E37_79B9 ^ 32'(t * 32'h0101_0101);
      c0 = cs_cnt;
      scan(mk_cpu(ta, 1'b1, td), 73, o); idle(20);
      check("R5 one write pulse", 32'(cs_cnt - c0), 32'd1);
      check("R5 write we", {31'b0, cs_we}, 32'd1);
      check("R5 write addr", cs_addr, ta);
      check("R5 write data", cs_data, td);
      rdata = ~td;
      c0 = cs_cnt;
      scan(mk_cpu(ta, 1'b0, 32'hFFFF_0000), 73, o); idle(20);
      check("R6 one read pulse", 32'(cs_cnt - c0), 32'd1);
      check("R6 read we", {31'b0, cs_we}, 32'd0);
      rdata = 32'h0;
      scan(mk_cpu(ta, 1'b0, 32'h0), 73, o); idle(20);
      check("R6 read data out", o[31:0], ~td);
    end

    // R10 trace chain: nothing issued, error flag kept
    ir = 4'h3;
    scan(mk_sel(4'd3), 12, o);
    ir = 4'h8;
    c0 = cs_cnt;
    f = mk_cpu(32'h10, 1'b1, 32'h77); f[70] = ~f[70];
    scan(f, 73, o); idle(20);
    check("R10 trace no request", 32'(cs_cnt - c0), 32'd0);
    check("R10 trace err untouched", {31'b0, crc_err}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule